// File: doc/BRIEF.md
# Indirect Configuration Address/Data Port Bridge

This block turns a small I/O window of eight byte addresses into indirect access to a configuration space. Offsets 0 to 3 hold a 32-bit selector word. Software writes this word to choose a target: an enable flag, a bus, a device, a function and a dword-aligned register number. Offsets 4 to 7 form a data window. A read or write there becomes a configuration access to the selected register. The position inside the window is added to the register number, so that 8- and 16-bit accesses reach sub-word fields.

An I/O request is a one-cycle strobe that carries an offset, an access size of 1, 2 or 4 bytes, a direction and write data. Each read is answered one cycle later on `io_rvalid`/`io_rdata`, right-aligned. The selector fields go straight to the downstream configuration-space target. That target answers with a combinational presence flag and read data. The bridge raises a read or write strobe only when the access is legal, enabled and aimed at a present function.

Top module: `cfg_port_bridge`

## Requirements
- R1: An access is legal only for size 4 at window offset 0, size 2 at offsets 0 or 2, or size 1 at any offset; size codes other than 1, 2 and 4 are illegal. An illegal access changes no state and raises no downstream strobe, and an illegal read returns 0xFFFFFFFF.
- R2: A legal write to offsets 0-3 updates only the addressed byte lanes of the selector. Writing 0x12345678 (size 4, offset 0), then 0xFACE (size 2, offset 2), then 0x99 (size 1, offset 1) leaves 0xFACE9978.
- R3: A legal read of offsets 0-3 returns the addressed lanes shifted down to bit 0, with the bits above the access width zero. With 0x12345678 stored, size 2 at offset 2 gives 0x1234 and size 1 at offset 1 gives 0x56.
- R4: Selector bits 1:0 always read as 0, whatever is written. The selector resets to 0.
- R5: The selector decodes as enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8, register number = bits 7:2. Bus, device and function are driven on `cfg_bus`, `cfg_dev` and `cfg_fn`.
- R6: A data-window read targets byte address {register number, window offset[1:0]} on `cfg_reg` and returns the dword shifted right by 8 × offset, masked to the access width. Size 2 and size 4 reads at offset 4 return the low half-word and the full dword. Size 2 at offset 6 returns the upper half-word.
- R7: A data-window write drives `cfg_be` = the access lanes shifted left by the offset, and `cfg_wdata` = the write data shifted left by 8 × offset. Only the addressed bytes of the target register change.
- R8: With enable clear, a data-window read returns all ones across the access width. A data-window write raises no strobe.
- R9: With enable set but `cfg_present` low, a data-window read returns all ones across the access width. A data-window write raises no strobe.
- R10: Every read request produces `io_rvalid` high for exactly the following cycle. Writes produce no response.
- R11: An accepted data-window read or write raises exactly one of `cfg_rd`/`cfg_wr` in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle I/O request strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_off | input | 3 | Window offset 0-7 |
| io_size | input | 3 | Access size in bytes (1, 2, 4) |
| io_wdata | input | 32 | Write data, right-aligned |
| io_rvalid | output | 1 | Read response valid |
| io_rdata | output | 32 | Read response data, right-aligned |
| cfg_rd | output | 1 | Downstream read strobe |
| cfg_wr | output | 1 | Downstream write strobe |
| cfg_bus | output | 8 | Selected bus |
| cfg_dev | output | 5 | Selected device |
| cfg_fn | output | 3 | Selected function |
| cfg_reg | output | 8 | Byte address inside the function's space |
| cfg_be | output | 4 | Write byte enables |
| cfg_wdata | output | 32 | Write data, lane-aligned |
| cfg_rdata | input | 32 | Dword read from the target (combinational) |
| cfg_present | input | 1 | Selected function exists (combinational) |

## Verification
Some sub-word accesses land on the data window while the selector points at a real register. Checking those is the hardest part. Reaching them takes a full selector write, and each partial write must then be read back as a whole dword, to prove that the neighbouring bytes survived. The bench keeps its own model of the target's registers and applies the byte enables it sees at each write strobe. It then compares the bytes returned at offsets 4-7 against that model. For the dropped-write cases, it counts write strobes and reads the register back after re-enabling the selector.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 8;
    localparam int RNUM_W  = REG_W - OFF_W;
    localparam int EN_BIT  = 31;
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int SEL_W   = BUS_LSB + BUS_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    typedef struct packed {
        word_t sel;
        word_t rdata;
        logic  rvalid;
    } state_t;

    function automatic word_t width_mask(input logic [2:0] size);
        case (size)
            3'd1:    width_mask = word_t'(8'hFF);
            3'd2:    width_mask = word_t'(16'hFFFF);
            default: width_mask = '1;
        endcase
    endfunction

    function automatic word_t lane_extract(input word_t w, input logic [OFF_W-1:0] off,
                                           input logic [2:0] size);
        lane_extract = (w >> {off, 3'b000}) & width_mask(size);
    endfunction

    function automatic word_t lane_merge(input word_t old, input word_t wdata,
                                         input logic [OFF_W-1:0] off, input lanes_t be);
        word_t bits;
        for (int i = 0; i < LANES; i++) begin
            bits[i*8 +: 8] = {8{be[i]}};
        end
        lane_merge = (old & ~bits) | ((wdata << {off, 3'b000}) & bits);
    endfunction
endpackage

// File: rtl/cfgp_lane_ctl.sv
module cfgp_lane_ctl
    import cfgp_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [2:0]       size,
    output logic             legal,
    output lanes_t           be
);
    lanes_t base;

    always_comb begin
        legal = 1'b0;
        base  = '0;
        case (size)
            3'd1: begin
                legal = 1'b1;
                base  = lanes_t'(1);
            end
            3'd2: begin
                legal = (off[0] == 1'b0);
                base  = lanes_t'(3);
            end
            3'd4: begin
                legal = (off == '0);
                base  = '1;
            end
            default: begin
                legal = 1'b0;
                base  = '0;
            end
        endcase
        be = legal ? lanes_t'(base << off) : '0;
    end
endmodule

// File: rtl/cfgp_sel_dec.sv
module cfgp_sel_dec
    import cfgp_pkg::*;
(
    input  logic                 en_bit,
    input  logic [SEL_W-1:OFF_W] sel_lo,
    output logic                 en,
    output logic [BUS_W-1:0]     bus,
    output logic [DEV_W-1:0]     dev,
    output logic [FN_W-1:0]      fn,
    output logic [RNUM_W-1:0]    rnum
);
    always_comb begin
        en   = en_bit;
        bus  = sel_lo[BUS_LSB +: BUS_W];
        dev  = sel_lo[DEV_LSB +: DEV_W];
        fn   = sel_lo[FN_LSB  +: FN_W];
        rnum = sel_lo[REG_W-1:OFF_W];
    end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [2:0]        io_off,
    input  logic [2:0]        io_size,
    input  logic [WORD_W-1:0] io_wdata,
    output logic              io_rvalid,
    output logic [WORD_W-1:0] io_rdata,
    output logic              cfg_rd,
    output logic              cfg_wr,
    output logic [BUS_W-1:0]  cfg_bus,
    output logic [DEV_W-1:0]  cfg_dev,
    output logic [FN_W-1:0]   cfg_fn,
    output logic [REG_W-1:0]  cfg_reg,
    output logic [LANES-1:0]  cfg_be,
    output logic [WORD_W-1:0] cfg_wdata,
    input  logic [WORD_W-1:0] cfg_rdata,
    input  logic              cfg_present
);
    state_t state_d, state_q;

    logic              legal;
    lanes_t            be;
    logic              sel_en;
    logic [RNUM_W-1:0] rnum;
    logic [OFF_W-1:0]  lane_off;
    logic              hit_sel;
    logic              hit_data;
    logic              data_ok;

    assign lane_off = io_off[OFF_W-1:0];

    cfgp_lane_ctl u_lane (
        .off   (lane_off),
        .size  (io_size),
        .legal (legal),
        .be    (be)
    );

    cfgp_sel_dec u_dec (
        .en_bit (state_q.sel[EN_BIT]),
        .sel_lo (state_q.sel[SEL_W-1:OFF_W]),
        .en     (sel_en),
        .bus    (cfg_bus),
        .dev    (cfg_dev),
        .fn     (cfg_fn),
        .rnum   (rnum)
    );

    always_comb begin
        hit_sel   = io_req && legal && !io_off[2];
        hit_data  = io_req && legal &&  io_off[2];
        data_ok   = hit_data && sel_en && cfg_present;
        cfg_rd    = data_ok && !io_we;
        cfg_wr    = data_ok &&  io_we;
        cfg_reg   = {rnum, lane_off};
        cfg_be    = be;
        cfg_wdata = io_wdata << {lane_off, 3'b000};

        state_d        = state_q;
        state_d.rvalid = io_req && !io_we;

        if (hit_sel && io_we) begin
            state_d.sel = lane_merge(state_q.sel, io_wdata, lane_off, be);
            state_d.sel[OFF_W-1:0] = '0;
        end

        if (io_req && !io_we) begin
            if (!legal) begin
                state_d.rdata = '1;
            end else if (!io_off[2]) begin
                state_d.rdata = lane_extract(state_q.sel, lane_off, io_size);
            end else if (data_ok) begin
                state_d.rdata = lane_extract(cfg_rdata, lane_off, io_size);
            end else begin
                state_d.rdata = width_mask(io_size);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign io_rvalid = state_q.rvalid;
    assign io_rdata  = state_q.rdata;
endmodule

// File: rtl/cfg_port_bridge_sva.sv
module cfg_port_bridge_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        io_req,
    input logic        io_we,
    input logic [2:0]  io_off,
    input logic [2:0]  io_size,
    input logic        io_rvalid,
    input logic        cfg_rd,
    input logic        cfg_wr,
    input logic        cfg_present,
    input logic [31:0] sel_q
);
    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_we) |=> io_rvalid);

    // R10
    no_spur_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && !io_we) |=> !io_rvalid);

    // R8
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd || cfg_wr) |-> (sel_q[31] && cfg_present));

    // R11
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd || cfg_wr) |-> (io_req && io_off[2] && $onehot0({cfg_rd, cfg_wr})
                                && (cfg_wr == io_we)));

    // R1
    strobe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd || cfg_wr) |-> ((io_size == 3'd1) ||
                                (io_size == 3'd2 && !io_off[0]) ||
                                (io_size == 3'd4 && io_off[1:0] == 2'b00)));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_off[2]) |=> $stable(sel_q));

    // R4
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[1:0] == 2'b00);
endmodule

bind cfg_port_bridge cfg_port_bridge_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_req      (io_req),
    .io_we       (io_we),
    .io_off      (io_off),
    .io_size     (io_size),
    .io_rvalid   (io_rvalid),
    .cfg_rd      (cfg_rd),
    .cfg_wr      (cfg_wr),
    .cfg_present (cfg_present),
    .sel_q       (state_q.sel)
);

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_we = 1'b0;
    logic [2:0]  io_off = '0;
    logic [2:0]  io_size = 3'd4;
    logic [31:0] io_wdata = '0;
    logic        io_rvalid;
    logic [31:0] io_rdata;
    logic        cfg_rd, cfg_wr;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [7:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        cfg_present;

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    logic [31:0] mem [64];

    always #10 clk = ~clk;

    cfg_port_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_off(io_off),
        .io_size(io_size), .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_present(cfg_present)
    );

    function automatic logic [31:0] init_word(input int i);
        init_word = 32'h8086_29C0 ^ (i * 32'h0103_0507);
    endfunction

    assign cfg_present = (cfg_bus == 8'h00) && (cfg_dev == 5'd3) && (cfg_fn == 3'd1);
    assign cfg_rdata   = mem[cfg_reg[7:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
        end else if (cfg_wr) begin
            wr_count <= wr_count + 1;
            for (int b = 0; b < 4; b++)
                if (cfg_be[b]) mem[cfg_reg[7:2]][b*8 +: 8] <= cfg_wdata[b*8 +: 8];
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish (got hang, expected completion)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic io(input logic we, input logic [2:0] off, input logic [2:0] size,
                      input logic [31:0] wd, output logic [31:0] rd, output logic rv);
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_off = off; io_size = size; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0;
        rd = io_rdata; rv = io_rvalid;
    endtask

    function automatic logic [31:0] sel(input logic en, input logic [7:0] b,
                                        input logic [4:0] d, input logic [2:0] f,
                                        input logic [7:0] r);
        sel = {en, 7'd0, b, d, f, r};
    endfunction

    task automatic t_reset();
        logic [31:0] rd; logic rv;
        check("R10 idle rvalid", {31'd0, io_rvalid}, 32'd0);
        io(1'b0, 3'd0, 3'd4, 0, rd, rv);
        check("R4 reset selector", rd, 32'd0);
        check("R10 read rvalid", {31'd0, rv}, 32'd1);
    endtask

    task automatic t_sel_lanes();
        logic [31:0] rd; logic rv;
        io(1'b1, 3'd0, 3'd4, 32'h12345678, rd, rv);
        check("R10 write no rvalid", {31'd0, rv}, 32'd0);
        io(1'b0, 3'd2, 3'd2, 0, rd, rv);
        check("R3 size2 off2", rd, 32'h1234);
        io(1'b0, 3'd1, 3'd1, 0, rd, rv);
        check("R3 size1 off1", rd, 32'h56);
        io(1'b1, 3'd2, 3'd2, 32'hFACE, rd, rv);
        io(1'b1, 3'd1, 3'd1, 32'h99, rd, rv);
        io(1'b0, 3'd0, 3'd4, 0, rd, rv);
        check("R2 lane merge", rd, 32'hFACE9978);
    endtask

    task automatic t_sel_rules();
        logic [31:0] rd; logic rv;
        io(1'b1, 3'd0, 3'd4, 32'h800000FF, rd, rv);
        io(1'b0, 3'd0, 3'd4, 0, rd, rv);
        check("R4 low bits forced", rd, 32'h800000FC);
        io(1'b1, 3'd1, 3'd2, 32'h0, rd, rv);
        io(1'b1, 3'd2, 3'd4, 32'h0, rd, rv);
        io(1'b1, 3'd0, 3'd3, 32'h0, rd, rv);
        io(1'b0, 3'd0, 3'd4, 0, rd, rv);
        check("R1 illegal writes ignored", rd, 32'h800000FC);
        io(1'b0, 3'd2, 3'd4, 0, rd, rv);
        check("R1 illegal read size4 off2", rd, 32'hFFFFFFFF);
        io(1'b0, 3'd3, 3'd2, 0, rd, rv);
        check("R1 illegal read size2 off3", rd, 32'hFFFFFFFF);
    endtask

    task automatic t_decode();
        logic [31:0] rd; logic rv;
        io(1'b1, 3'd0, 3'd4, sel(1'b1, 8'hA5, 5'd22, 3'd6, 8'h40), rd, rv);
        check("R5 bus field", {24'd0, cfg_bus}, 32'hA5);
        check("R5 dev field", {27'd0, cfg_dev}, 32'd22);
        check("R5 fn field", {29'd0, cfg_fn}, 32'd6);
    endtask

    task automatic t_data_read();
        logic [31:0] rd; logic rv;
        logic [31:0] w;
        w = init_word(4);
        io(1'b1, 3'd0, 3'd4, sel(1'b1, 8'h00, 5'd3, 3'd1, 8'h10), rd, rv);
        io(1'b0, 3'd4, 3'd2, 0, rd, rv);
        check("R6 size2 off4", rd, {16'd0, w[15:0]});
        io(1'b0, 3'd4, 3'd4, 0, rd, rv);
        check("R6 size4 off4", rd, w);
        io(1'b0, 3'd6, 3'd2, 0, rd, rv);
        check("R6 size2 off6", rd, {16'd0, w[31:16]});
        io(1'b0, 3'd7, 3'd1, 0, rd, rv);
        check("R6 size1 off7", rd, {24'd0, w[31:24]});
    endtask

    task automatic t_data_write();
        logic [31:0] rd; logic rv;
        logic [31:0] w;
        int n0;
        w = init_word(4);
        n0 = wr_count;
        io(1'b1, 3'd5, 3'd1, 32'hEE, rd, rv);
        check("R11 one write strobe", wr_count - n0, 1);
        io(1'b0, 3'd4, 3'd4, 0, rd, rv);
        check("R7 byte write lane1", rd, {w[31:16], 8'hEE, w[7:0]});
        io(1'b1, 3'd6, 3'd2, 32'hBEEF, rd, rv);
        io(1'b0, 3'd4, 3'd4, 0, rd, rv);
        check("R7 half write upper", rd, {16'hBEEF, 8'hEE, w[7:0]});
    endtask

    task automatic t_disabled();
        logic [31:0] rd; logic rv;
        logic [31:0] w;
        int n0;
        w = init_word(4);
        n0 = wr_count;
        io(1'b1, 3'd0, 3'd4, sel(1'b0, 8'h00, 5'd3, 3'd1, 8'h10), rd, rv);
        io(1'b0, 3'd4, 3'd2, 0, rd, rv);
        check("R8 disabled read", rd, 32'h0000FFFF);
        io(1'b1, 3'd4, 3'd4, 32'h0, rd, rv);
        check("R8 disabled no strobe", wr_count - n0, 0);
        io(1'b1, 3'd3, 3'd1, 32'h80, rd, rv);
        io(1'b0, 3'd4, 3'd4, 0, rd, rv);
        check("R8 register kept", rd, {16'hBEEF, 8'hEE, w[7:0]});
    endtask

    task automatic t_absent();
        logic [31:0] rd; logic rv;
        int n0;
        n0 = wr_count;
        io(1'b1, 3'd0, 3'd4, sel(1'b1, 8'h00, 5'd4, 3'd1, 8'h10), rd, rv);
        io(1'b0, 3'd4, 3'd4, 0, rd, rv);
        check("R9 absent read", rd, 32'hFFFFFFFF);
        io(1'b0, 3'd5, 3'd1, 0, rd, rv);
        check("R9 absent byte read", rd, 32'h000000FF);
        io(1'b1, 3'd4, 3'd4, 32'h0, rd, rv);
        check("R9 absent no strobe", wr_count - n0, 0);
    endtask

    task automatic t_data_illegal();
        logic [31:0] rd; logic rv;
        int n0;
        io(1'b1, 3'd0, 3'd4, sel(1'b1, 8'h00, 5'd3, 3'd1, 8'h20), rd, rv);
        n0 = wr_count;
        io(1'b0, 3'd5, 3'd4, 0, rd, rv);
        check("R1 data illegal read", rd, 32'hFFFFFFFF);
        io(1'b1, 3'd5, 3'd2, 32'h0, rd, rv);
        check("R1 data illegal no strobe", wr_count - n0, 0);
        io(1'b0, 3'd4, 3'd4, 0, rd, rv);
        check("R1 data register intact", rd, init_word(8));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sel_lanes();
        t_sel_rules();
        t_decode();
        t_data_read();
        t_data_write();
        t_disabled();
        t_absent();
        t_data_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule